// File: doc/BRIEF.md
# Bus-Snooping Bank Window MMU

This block sits next to an 8-bit CPU bus with 16-bit addresses and widens it to a 20-bit physical address (1 MiB). It has no registers that software reads or writes. It watches opcode fetches and gives new meaning to four opcodes that the CPU treats as multi-byte no-operations. One sets an enable register. One queues a bank for data accesses. One queues a bank for a jump or call. The fourth is held back for later use and only has its operand bytes consumed.

Every CPU access whose address lies in the 4 KiB window `$A000`–`$AFFF` is steered to `{bank, addr[11:0]}`. Pending bank prefixes are kept in a 256-entry last-in-first-out store, so an interrupt that arrives between a prefix and the instruction that uses it does no harm.

A small return-bank stack follows calls and returns, so a subroutine return goes back into the caller's bank. While the unit is disabled it is fully transparent.

Top module: `bank_window_mmu`

## Requirements
- R1: After reset the unit is disabled, both stacks are empty, `lifo_err_o` is 0 and `phys_addr_o` equals `{4'h0, addr_i}`.
- R2: A fetch of opcode `$82` followed by its operand byte sets the unit enabled when operand bits 7:4 are `0101` and disabled otherwise. Operand bits 3:0 have no effect.
- R3: While disabled, `phys_addr_o` equals `{4'h0, addr_i}` for every address, and bank prefixes (`$FC`, `$DC`) are ignored: no entry is queued.
- R4: While enabled, an access with `addr_i[15:12] == 4'hA` drives `phys_addr_o = {bank, addr_i[11:0]}`. Any other address drives `{4'h0, addr_i}`.
- R5: Opcode `$FC` queues the first operand byte as a data bank. The first non-code window access after it takes the newest data entry. Every further window access of that same instruction uses the same bank, and the entry is removed at the next opcode fetch.
- R6: Queued banks are used newest first: prefixes `$12` then `$13`, followed by two window loads, reach bank `$13` and then bank `$12`.
- R7: Opcode `$DC` queues a jump bank. The opcode fetch that follows a JSR (`$20`) or JMP (`$4C`) into the window runs in the newest jump bank if one is on top, and in bank `$00` otherwise. Later code in the window stays in that bank.
- R8: A JSR records the bank it was fetched from. The opcode fetch after an RTS (`$60`) runs in the recorded bank, so a caller in the window gets its bank back and a caller outside the window sees a plain 16-bit address.
- R9: Opcode `$5C` consumes two operand bytes and changes neither the enable state nor the queued banks.
- R10: Code reads (opcode fetches, and reads at the address that follows the previous code read) in the window use the current code bank, never a pending data bank.
- R11: `lifo_err_o` is set and stays set until reset on a push to a full stack (the 257th pending prefix) or a pop from an empty one (an RTS with no recorded call).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one CPU bus cycle per edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| data_i | input | 8 | CPU read data (opcode and operand bytes) |
| rw_i | input | 1 | 1 = read, 0 = write |
| sync_i | input | 1 | High in opcode-fetch cycles |
| phys_addr_o | output | 20 | Extended physical address |
| lifo_err_o | output | 1 | Sticky stack overflow or underflow flag |

## Verification
The hardest state to reach is a call made from inside a banked window while a data prefix is still pending. That state has to produce three things in order: the old data entry removed at the call's opcode fetch, a target fetch in bank `$00` because no jump entry is on top, and a return fetch back in the caller's bank. The bench builds this from full instruction bus sequences. It first enters bank `$05` through a jump prefix and a JMP. It then queues a data prefix and uses it in a load. Finally it issues JSR and RTS with their stack cycles modelled. A second call from outside the window confirms that the return falls back to a plain address. Overflow is reached by issuing 257 prefixes in a row.

// File: rtl/bwmmu_pkg.sv
package bwmmu_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_OPL, ST_OPH} dec_st_e;
  typedef enum logic [1:0] {K_CTRL, K_DATA, K_JUMP, K_RSV} pfx_kind_e;

  typedef struct packed {
    logic       jump;
    logic [7:0] bank;
  } pfx_ent_t;

  localparam logic [7:0] OP_CTRL = 8'h82;
  localparam logic [7:0] OP_DPFX = 8'hFC;
  localparam logic [7:0] OP_JPFX = 8'hDC;
  localparam logic [7:0] OP_RSV  = 8'h5C;
  localparam logic [7:0] OP_JSR  = 8'h20;
  localparam logic [7:0] OP_JMP  = 8'h4C;
  localparam logic [7:0] OP_RTS  = 8'h60;
  localparam logic [3:0] EN_KEY  = 4'h5;
endpackage

// File: rtl/bwmmu_lifo.sv
module bwmmu_lifo #(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 256
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         err_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW:0]   cnt_q;
  logic          err_q;
  logic          full;
  logic [AW-1:0] top_idx, wr_idx;
  logic          do_wr;

  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign top_idx = cnt_q[AW-1:0] - 1'b1;
  assign top_o   = mem[top_idx];
  assign err_o   = err_q;

  // push with pop on a non-empty stack replaces the top entry
  assign wr_idx = (pop_i && !empty_o) ? top_idx : cnt_q[AW-1:0];
  assign do_wr  = push_i && ((pop_i && !empty_o) || !full);

  always_ff @(posedge clk_i) begin
    if (do_wr) mem[wr_idx] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if ((push_i && !pop_i && full) || (pop_i && empty_o)) err_q <= 1'b1;
      if (push_i && !pop_i && !full)        cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i && !empty_o) cnt_q <= cnt_q - 1'b1;
      else if (push_i && pop_i && empty_o)   cnt_q <= cnt_q + 1'b1;
    end
  end

  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= (AW+1)'(DEPTH));
  p_err_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  p_full_push_flags_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && full) |=> err_q);
endmodule

// File: rtl/bwmmu_decode.sv
module bwmmu_decode
  import bwmmu_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] addr_i,
  input  logic [7:0]  data_i,
  input  logic        rw_i,
  input  logic        sync_i,
  output logic        code_o,
  output logic        ctrl_wr_o,
  output logic        push_o,
  output logic        push_jump_o,
  output logic [7:0]  operand_o,
  output logic        jsr_o,
  output logic        jmp_o,
  output logic        rts_o
);
  dec_st_e   state_q;
  pfx_kind_e kind_q;
  logic [15:0] seq_q;
  logic        seq_vld_q;
  logic        op_fetch, opl_hit;

  assign op_fetch = sync_i && rw_i;
  // code read: opcode fetch or read at the next sequential code address
  assign code_o   = op_fetch || (rw_i && seq_vld_q && (addr_i == seq_q));
  assign opl_hit  = code_o && !sync_i && (state_q == ST_OPL);

  assign operand_o   = data_i;
  assign ctrl_wr_o   = opl_hit && (kind_q == K_CTRL);
  assign push_o      = opl_hit && ((kind_q == K_DATA) || (kind_q == K_JUMP));
  assign push_jump_o = (kind_q == K_JUMP);
  assign jsr_o       = op_fetch && (data_i == OP_JSR);
  assign jmp_o       = op_fetch && (data_i == OP_JMP);
  assign rts_o       = op_fetch && (data_i == OP_RTS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_q    <= K_CTRL;
      seq_q     <= '0;
      seq_vld_q <= 1'b0;
    end else begin
      if (code_o) begin
        seq_q     <= addr_i + 16'd1;
        seq_vld_q <= 1'b1;
      end
      if (op_fetch) begin
        state_q <= ST_OPL;
        unique case (data_i)
          OP_CTRL: kind_q <= K_CTRL;
          OP_DPFX: kind_q <= K_DATA;
          OP_JPFX: kind_q <= K_JUMP;
          OP_RSV:  kind_q <= K_RSV;
          default: state_q <= ST_IDLE;
        endcase
      end else if (code_o) begin
        unique case (state_q)
          ST_OPL:  state_q <= (kind_q == K_CTRL) ? ST_IDLE : ST_OPH;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  p_rsv_consumes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_fetch && data_i == OP_RSV) |=> (state_q == ST_OPL && kind_q == K_RSV));
  p_opcode_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_fetch && data_i != OP_CTRL && data_i != OP_DPFX && data_i != OP_JPFX
     && data_i != OP_RSV) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/bank_window_mmu.sv
module bank_window_mmu
  import bwmmu_pkg::*;
#(
  parameter int unsigned WIN_BITS  = 12,
  parameter int unsigned WIN_TAG   = 'hA,
  parameter int unsigned PFX_DEPTH = 256,
  parameter int unsigned RET_DEPTH = 64,
  localparam int unsigned PA_W     = WIN_BITS + 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [15:0]     addr_i,
  input  logic [7:0]      data_i,
  input  logic            rw_i,
  input  logic            sync_i,
  output logic [PA_W-1:0] phys_addr_o,
  output logic            lifo_err_o
);
  localparam int unsigned TAG_W = 16 - WIN_BITS;

  logic       code_c, ctrl_wr, push_pfx, push_jump, jsr_c, jmp_c, rts_c;
  logic [7:0] operand;
  logic       en_q, jump_arm_q, ret_arm_q, data_hit_q;
  logic [7:0] code_bank_q, data_bank_q;
  logic       in_win, jmp_take, data_take;
  logic [7:0] jmp_bank, ret_bank, sync_bank, bank_sel;
  pfx_ent_t   dl_top, dl_din;
  logic       dl_empty, dl_err, dl_pop;
  logic [7:0] rl_top;
  logic       rl_empty, rl_err;

  bwmmu_decode u_dec (
    .clk_i, .rst_ni, .addr_i, .data_i, .rw_i, .sync_i,
    .code_o(code_c), .ctrl_wr_o(ctrl_wr), .push_o(push_pfx),
    .push_jump_o(push_jump), .operand_o(operand),
    .jsr_o(jsr_c), .jmp_o(jmp_c), .rts_o(rts_c)
  );

  assign in_win = (addr_i[15:WIN_BITS] == TAG_W'(WIN_TAG));

  assign jmp_take  = sync_i && jump_arm_q && en_q && in_win && !dl_empty && dl_top.jump;
  assign jmp_bank  = jmp_take ? dl_top.bank : 8'h00;
  assign ret_bank  = rl_empty ? 8'h00 : rl_top;
  assign sync_bank = jump_arm_q ? jmp_bank : (ret_arm_q ? ret_bank : code_bank_q);
  assign data_take = en_q && in_win && !code_c && !data_hit_q && !dl_empty && !dl_top.jump;

  always_comb begin
    if (sync_i)          bank_sel = sync_bank;
    else if (code_c)     bank_sel = code_bank_q;
    else if (data_hit_q) bank_sel = data_bank_q;
    else if (data_take)  bank_sel = dl_top.bank;
    else                 bank_sel = code_bank_q;
  end

  assign phys_addr_o = (en_q && in_win) ? {bank_sel, addr_i[WIN_BITS-1:0]}
                                        : PA_W'(addr_i);

  assign dl_din = '{jump: push_jump, bank: operand};
  assign dl_pop = (sync_i && data_hit_q) || jmp_take;

  bwmmu_lifo #(.W($bits(pfx_ent_t)), .DEPTH(PFX_DEPTH)) u_pfx_lifo (
    .clk_i, .rst_ni, .push_i(push_pfx && en_q), .pop_i(dl_pop),
    .din_i(dl_din), .top_o(dl_top), .empty_o(dl_empty), .err_o(dl_err)
  );

  bwmmu_lifo #(.W(8), .DEPTH(RET_DEPTH)) u_ret_lifo (
    .clk_i, .rst_ni, .push_i(jsr_c), .pop_i(sync_i && ret_arm_q),
    .din_i(sync_bank), .top_o(rl_top), .empty_o(rl_empty), .err_o(rl_err)
  );

  assign lifo_err_o = dl_err || rl_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= 1'b0;
      jump_arm_q  <= 1'b0;
      ret_arm_q   <= 1'b0;
      data_hit_q  <= 1'b0;
      code_bank_q <= '0;
      data_bank_q <= '0;
    end else begin
      if (ctrl_wr) en_q <= (operand[7:4] == EN_KEY);
      if (sync_i) begin
        jump_arm_q  <= jsr_c || jmp_c;
        ret_arm_q   <= rts_c;
        data_hit_q  <= 1'b0;
        code_bank_q <= sync_bank;
      end else if (data_take) begin
        data_hit_q  <= 1'b1;
        data_bank_q <= dl_top.bank;
      end
    end
  end

  p_off_transparent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (phys_addr_o == PA_W'(addr_i)));
  p_outside_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win |-> (phys_addr_o == PA_W'(addr_i)));
  p_win_low_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_win |-> (phys_addr_o[WIN_BITS-1:0] == addr_i[WIN_BITS-1:0]));
  p_jump_default_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && jump_arm_q && en_q && in_win && dl_empty)
      |-> (phys_addr_o[PA_W-1:WIN_BITS] == 8'h00));
  p_en_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && operand[7:4] != EN_KEY) |=> !en_q);
endmodule

// File: tb/bank_window_mmu_tb.sv
`timescale 1ns/1ps
module bank_window_mmu_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        rw = 1'b1;
  logic        sync = 1'b0;
  logic [19:0] phys;
  logic        err;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  bank_window_mmu u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .data_i(data),
    .rw_i(rw), .sync_i(sync), .phys_addr_o(phys), .lifo_err_o(err)
  );

  task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic w, input logic s);
    @(negedge clk);
    addr = a; data = d; rw = w; sync = s;
    #1;
  endtask
  task automatic fetch(input logic [15:0] a, input logic [7:0] op); bus(a, op, 1'b1, 1'b1); endtask
  task automatic rd(input logic [15:0] a, input logic [7:0] d); bus(a, d, 1'b1, 1'b0); endtask
  task automatic wr(input logic [15:0] a, input logic [7:0] d); bus(a, d, 1'b0, 1'b0); endtask

  task automatic chk(input string req, input logic [19:0] exp);
    checks++;
    if (phys !== exp) begin
      fails++;
      $display("FAIL %s: phys=%05h expected %05h", req, phys, exp);
    end
  endtask
  task automatic chk_err(input string req, input logic exp);
    checks++;
    if (err !== exp) begin
      fails++;
      $display("FAIL %s: err=%0b expected %0b", req, err, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; sync = 1'b0; rw = 1'b1; addr = '0; data = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask
  task automatic ctrl(input logic [15:0] a, input logic [7:0] v);
    fetch(a, 8'h82); rd(a + 16'd1, v);
  endtask
  task automatic pfx(input logic [15:0] a, input logic [7:0] op, input logic [7:0] lo);
    fetch(a, op); rd(a + 16'd1, lo); rd(a + 16'd2, 8'h00);
  endtask
  task automatic lda(input logic [15:0] a, input logic [15:0] t);
    fetch(a, 8'hAD); rd(a + 16'd1, t[7:0]); rd(a + 16'd2, t[15:8]);
  endtask

  task automatic t_reset();
    do_reset();
    rd(16'hA345, 8'h00); chk("R1 reset transparent", 20'h0A345);
    chk_err("R1 reset err clear", 1'b0);
  endtask

  task automatic t_disabled();
    do_reset();
    pfx(16'h0200, 8'hFC, 8'h12);
    lda(16'h0203, 16'hA345);
    rd(16'hA345, 8'h00); chk("R3 disabled window passthrough", 20'h0A345);
    ctrl(16'h0206, 8'h50);
    lda(16'h0208, 16'hA345);
    rd(16'hA345, 8'h00); chk("R3 prefix ignored while disabled", 20'h00345);
  endtask

  task automatic t_ctrl();
    do_reset();
    ctrl(16'h0200, 8'h5F);
    rd(16'hA345, 8'h00); chk("R2 key 5F enables", 20'h00345);
    ctrl(16'h0202, 8'hA5);
    rd(16'hA345, 8'h00); chk("R2 key A5 disables", 20'h0A345);
    ctrl(16'h0204, 8'h50);
    rd(16'hA345, 8'h00); chk("R2 key 50 enables", 20'h00345);
    ctrl(16'h0206, 8'h40);
    rd(16'hA345, 8'h00); chk("R2 key 40 disables", 20'h0A345);
  endtask

  task automatic t_window();
    do_reset();
    ctrl(16'h0200, 8'h50);
    rd(16'h9FFF, 8'h00); chk("R4 below window", 20'h09FFF);
    rd(16'hB000, 8'h00); chk("R4 above window", 20'h0B000);
    rd(16'hA000, 8'h00); chk("R4 window base bank 0", 20'h00000);
    pfx(16'h0202, 8'hFC, 8'h3C);
    lda(16'h0205, 16'hAFFF);
    rd(16'hAFFF, 8'h00); chk("R4 window top banked", 20'h3CFFF);
    rd(16'hB000, 8'h00); chk("R4 outside while banked", 20'h0B000);
  endtask

  task automatic t_lifo();
    do_reset();
    ctrl(16'h0200, 8'h50);
    pfx(16'h0202, 8'hFC, 8'h12);
    pfx(16'h0205, 8'hFC, 8'h13);
    lda(16'h0208, 16'hA345);
    rd(16'hA345, 8'h00); chk("R6 newest bank first", 20'h13345);
    lda(16'h020B, 16'hA345);
    rd(16'hA345, 8'h00); chk("R6 older bank second", 20'h12345);
    pfx(16'h020E, 8'hFC, 8'h22);
    fetch(16'h0211, 8'hEE); rd(16'h0212, 8'h10); rd(16'h0213, 8'hA0);
    rd(16'hA010, 8'h05); chk("R5 rmw read", 20'h22010);
    wr(16'hA010, 8'h05); chk("R5 rmw dummy write same bank", 20'h22010);
    wr(16'hA010, 8'h06); chk("R5 rmw write same bank", 20'h22010);
    lda(16'h0214, 16'hA010);
    rd(16'hA010, 8'h00); chk("R5 entry removed after use", 20'h00010);
  endtask

  task automatic t_rsv();
    do_reset();
    ctrl(16'h0200, 8'h50);
    pfx(16'h0202, 8'h5C, 8'h34);
    lda(16'h0205, 16'hA001);
    rd(16'hA001, 8'h00); chk("R9 reserved opcode no bank", 20'h00001);
    pfx(16'h0208, 8'hFC, 8'h44);
    pfx(16'h020B, 8'h5C, 8'h77);
    lda(16'h020E, 16'hA001);
    rd(16'hA001, 8'h00); chk("R9 reserved opcode keeps queue", 20'h44001);
    rd(16'h0300, 8'h00); chk("R9 still enabled outside", 20'h00300);
  endtask

  task automatic t_jump();
    do_reset();
    ctrl(16'h0200, 8'h50);
    pfx(16'h0202, 8'hDC, 8'h05);
    fetch(16'h0205, 8'h4C); rd(16'h0206, 8'h00); rd(16'h0207, 8'hA0);
    fetch(16'hA000, 8'hEA); chk("R7 jmp into jump bank", 20'h05000);
    rd(16'hA001, 8'h00); chk("R10 sequential code read", 20'h05001);
    fetch(16'hA001, 8'hFC); chk("R7 code stays in bank", 20'h05001);
    rd(16'hA002, 8'h07); chk("R10 prefix operand uses code bank", 20'h05002);
    rd(16'hA003, 8'h00);
    fetch(16'hA004, 8'hAD); chk("R10 fetch ignores data prefix", 20'h05004);
    rd(16'hA005, 8'h00); chk("R10 operand ignores data prefix", 20'h05005);
    rd(16'hA006, 8'hA1);
    rd(16'hA100, 8'h00); chk("R5 data from code in window", 20'h07100);
    fetch(16'hA007, 8'h20); chk("R8 jsr fetched in bank", 20'h05007);
    rd(16'hA008, 8'h00); rd(16'h01FF, 8'h00);
    wr(16'h01FF, 8'hA0); wr(16'h01FE, 8'h09);
    rd(16'hA009, 8'hA8);
    fetch(16'hA800, 8'hEA); chk("R7 call without prefix bank 0", 20'h00800);
    rd(16'hA801, 8'h00);
    fetch(16'hA801, 8'h60);
    rd(16'hA802, 8'h00); rd(16'h01FD, 8'h00);
    rd(16'h01FE, 8'h09); rd(16'h01FF, 8'hA0); rd(16'hA009, 8'h00);
    fetch(16'hA00A, 8'h4C); chk("R8 return to caller bank", 20'h0500A);
    rd(16'hA00B, 8'h23); rd(16'hA00C, 8'hA1);
    fetch(16'hA123, 8'hEA); chk("R7 jmp without prefix bank 0", 20'h00123);
    chk_err("R11 no error on balanced use", 1'b0);
  endtask

  task automatic t_ret_outside();
    do_reset();
    ctrl(16'h0200, 8'h50);
    pfx(16'h0202, 8'hDC, 8'h09);
    fetch(16'h0205, 8'h20); rd(16'h0206, 8'h00); rd(16'h01FF, 8'h00);
    wr(16'h01FF, 8'h02); wr(16'h01FE, 8'h07);
    rd(16'h0207, 8'hA2);
    fetch(16'hA200, 8'h60); chk("R7 jsr into jump bank", 20'h09200);
    rd(16'hA201, 8'h00); rd(16'h01FD, 8'h00);
    rd(16'h01FE, 8'h07); rd(16'h01FF, 8'h02); rd(16'h0207, 8'h00);
    fetch(16'h0208, 8'hEA); chk("R8 return outside window plain", 20'h00208);
    rd(16'h0209, 8'h00);
    rd(16'hA500, 8'h00); chk("R8 caller bank restored to 0", 20'h00500);
  endtask

  task automatic t_err();
    do_reset();
    ctrl(16'h0200, 8'h50);
    fetch(16'h0202, 8'h60); rd(16'h0203, 8'h00);
    fetch(16'h0204, 8'hEA);
    rd(16'h0205, 8'h00); chk_err("R11 underflow flagged", 1'b1);
    rd(16'h0300, 8'h00); rd(16'h0301, 8'h00);
    chk_err("R11 error sticky", 1'b1);
    do_reset();
    rd(16'h0000, 8'h00); chk_err("R1 reset clears error", 1'b0);
    ctrl(16'h1000, 8'h50);
    for (int i = 0; i < 256; i++) pfx(16'h1002 + 16'(3*i), 8'hFC, 8'(i));
    chk_err("R11 full stack no error", 1'b0);
    pfx(16'h1002 + 16'(3*256), 8'hFC, 8'hEE);
    chk_err("R11 overflow flagged", 1'b1);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_disabled();
    t_ctrl();
    t_window();
    t_lifo();
    t_rsv();
    t_jump();
    t_ret_outside();
    t_err();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule